// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block holds a small MAC forwarding table for a switch and lets a host manage it through a few write-only registers and a set of read-back outputs. To issue a command, the host first loads a 48-bit MAC address into a low data word and a high data word. It then writes a command word. The command word selects an operation: hash lookup, read by slot, write by slot, clear one slot, remove a port from every entry, or wipe the whole table. The host waits until `busy` drops. It then reads the slot address and the entry fields back from the data outputs.

Each slot stores a MAC address, a per-port membership mask, a priority, a static flag and a valid flag. A hidden hit flag supports ageing. No VLAN identifier is stored. The block also keeps a learned-entry counter, which the host steps up or down or zeroes. It also runs an ageing walker. The walker is paced by a prescaler and by a host-set period, and it retires dynamic entries that have seen no hit since its previous visit.

Top module: `mac_table_ctrl`

## Requirements
- R1: A command write accepted while idle raises `busy` on the next cycle. Lookup, read, write and clear-slot finish one cycle later. Port removal and table wipe keep `busy` high for exactly ENTRIES cycles. The command word holds lookup at bit 8, read at bit 9, write at bit 10, clear-slot at bit 11, port removal at bit 12 and table wipe at bit 13. When several of these bits are set, the highest one wins. Bits [4:0] carry the slot address or the port mask.
- R2: While `busy` is high, writes to the command word and to both data words are ignored. A command word with none of bits 13..8 set is also ignored and does not raise `busy`.
- R3: A lookup places in `entry_addr` the 5-bit hash of the MAC. The hash is the XOR of the MAC's consecutive 5-bit slices, starting at bit 0, with the last slice zero-padded.
- R4: When the hashed slot is valid and holds the same MAC, a lookup returns that slot's mask, priority, static flag and valid=1 in `data_hi`, and marks the slot as hit.
- R5: When the hashed slot is invalid or holds a different MAC, a lookup returns mask 0x1F, priority 0, static 0 and valid 0, with the MAC's upper 16 bits kept.
- R6: The layout of `data_hi` is: MAC[47:32] at [15:0], port mask at [20:16], priority at [23:21], static at [24], valid at [25]. A write stores the loaded MAC and these fields at the addressed slot and marks it hit. A read returns them, with MAC[31:0] in `data_lo`.
- R7: A clear-slot command zeroes the slot's mask, priority, static and valid fields.
- R8: Port removal clears the given mask bits in every entry. It invalidates every entry whose mask becomes empty.
- R9: During a table wipe, `clearing` is high. When it falls, every entry is invalid with zero mask, priority and static fields.
- R10: A learn-count write with mode 1 increments the count, saturating at ENTRIES. Mode 2 decrements it, saturating at 0. Mode 3 sets it to 0. Mode 0 does nothing. Table commands never change the count.
- R11: With a nonzero ageing period P, one slot is visited every P×PRESCALE cycles, in round-robin order. On a visit, a valid non-static slot with a clear hit flag is invalidated; any other slot has its hit flag cleared. A period of 0 stops ageing.
- R12: After reset, `busy`, `clearing`, `learn_count` and both data words are 0, and all slots are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register select: 0 data low, 1 data high, 2 command, 3 learn count, 4 ageing period |
| wr_data | input | 32 | Host write data |
| data_lo | output | 32 | Data low word (MAC[31:0]) |
| data_hi | output | 32 | Data high word (MAC[47:32] and entry fields) |
| busy | output | 1 | Command in progress |
| entry_addr | output | 5 | Slot address of the last command or lookup |
| clearing | output | 1 | Table wipe in progress |
| learn_count | output | 6 | Learned-entry counter |

## Verification
The bench looks up a second MAC whose hash collides with a stored one. A design that compared only the slot's valid bit would report a false hit there instead of the all-ports miss. During a port-removal sweep, it fires a clear-slot command and a data write. A design that let commands in while busy would lose an entry or corrupt the data word. It removes a port that is the only member of an entry. A design that left such an entry valid would keep forwarding to an empty mask. It also saturates the learn counter at both ends, and runs the ageing walker long enough that dynamic entries must vanish while static ones survive.

// File: rtl/mac_table_ctrl.sv
module mac_table_ctrl #(
  parameter int ENTRIES  = 32,
  parameter int NPORTS   = 5,
  parameter int PRIO_W   = 3,
  parameter int PRESCALE = 1024,
  parameter int AGE_W    = 16,
  localparam int AW = $clog2(ENTRIES),
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [31:0]   wr_data,
  output logic [31:0]   data_lo,
  output logic [31:0]   data_hi,
  output logic          busy,
  output logic [AW-1:0] entry_addr,
  output logic          clearing,
  output logic [CW-1:0] learn_count
);
  localparam int MSK_B = 16;
  localparam int PRI_B = MSK_B + NPORTS;
  localparam int STA_B = PRI_B + PRIO_W;
  localparam int VLD_B = STA_B + 1;
  localparam int PW    = $clog2(PRESCALE);
  localparam logic [2:0] SEL_LO = 3'd0, SEL_HI = 3'd1, SEL_CMD = 3'd2,
                         SEL_LRN = 3'd3, SEL_AGE = 3'd4;

  typedef enum logic [2:0] {OP_LOOKUP, OP_READ, OP_WRITE, OP_CLR, OP_DELP, OP_WIPE} op_t;
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_SWEEP} st_t;

  logic [47:0]       mac_q  [ENTRIES];
  logic [NPORTS-1:0] mask_q [ENTRIES];
  logic [PRIO_W-1:0] prio_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, stat_q, hit_q;

  st_t   state;
  op_t   op_q, new_op;
  logic [NPORTS-1:0] pm_q;
  logic [AW-1:0]     sweep_idx, age_ptr, hash;
  logic [AGE_W-1:0]  age_q, sub_q;
  logic [PW-1:0]     pre_q;
  logic              age_pend;
  logic [47:0]       mac_in;
  logic              cmd_go, host_ok, match;

  function automatic logic [31:0] pack_hi(input logic [15:0] mh, input logic [NPORTS-1:0] m,
                                          input logic [PRIO_W-1:0] p, input logic s, input logic v);
    logic [31:0] r;
    r = '0;
    r[15:0] = mh;
    r[MSK_B +: NPORTS] = m;
    r[PRI_B +: PRIO_W] = p;
    r[STA_B] = s;
    r[VLD_B] = v;
    return r;
  endfunction

  assign busy     = (state != ST_IDLE);
  assign clearing = (state == ST_SWEEP) && (op_q == OP_WIPE);
  assign mac_in   = {data_hi[15:0], data_lo};
  assign host_ok  = wr_en && !busy;
  assign cmd_go   = host_ok && (wr_sel == SEL_CMD) && (|wr_data[13:8]);
  assign match    = vld_q[hash] && (mac_q[hash] == mac_in);

  always_comb begin
    hash = '0;
    for (int i = 0; i < 48; i++) hash[i % AW] ^= mac_in[i];
  end

  always_comb begin
    if (wr_data[13])      new_op = OP_WIPE;
    else if (wr_data[12]) new_op = OP_DELP;
    else if (wr_data[11]) new_op = OP_CLR;
    else if (wr_data[10]) new_op = OP_WRITE;
    else if (wr_data[9])  new_op = OP_READ;
    else                  new_op = OP_LOOKUP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  op_q <= OP_LOOKUP;  pm_q <= '0;
      data_lo <= '0;  data_hi <= '0;  entry_addr <= '0;
      sweep_idx <= '0;  age_ptr <= '0;  age_q <= '0;  sub_q <= '0;
      pre_q <= '0;  age_pend <= 1'b0;  learn_count <= '0;
      vld_q <= '0;  stat_q <= '0;  hit_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        mac_q[i] <= '0;  mask_q[i] <= '0;  prio_q[i] <= '0;
      end
    end else begin
      if (host_ok && wr_sel == SEL_LO) data_lo <= wr_data;
      if (host_ok && wr_sel == SEL_HI) data_hi <= wr_data;

      if (wr_en && wr_sel == SEL_LRN) begin
        case (wr_data[1:0])
          2'd1: if (learn_count < CW'(ENTRIES)) learn_count <= learn_count + 1'b1;
          2'd2: if (learn_count != '0) learn_count <= learn_count - 1'b1;
          2'd3: learn_count <= '0;
          default: ;
        endcase
      end

      case (state)
        ST_IDLE: begin
          if (age_pend) begin
            age_pend <= 1'b0;
            age_ptr  <= age_ptr + 1'b1;
            if (vld_q[age_ptr] && !stat_q[age_ptr] && !hit_q[age_ptr]) vld_q[age_ptr] <= 1'b0;
            else hit_q[age_ptr] <= 1'b0;
          end
          if (cmd_go) begin
            op_q       <= new_op;
            entry_addr <= wr_data[AW-1:0];
            pm_q       <= wr_data[NPORTS-1:0];
            sweep_idx  <= '0;
            state      <= (new_op == OP_DELP || new_op == OP_WIPE) ? ST_SWEEP : ST_EXEC;
          end
        end
        ST_EXEC: begin
          state <= ST_IDLE;
          case (op_q)
            OP_LOOKUP: begin
              entry_addr <= hash;
              if (match) begin
                data_hi <= pack_hi(mac_q[hash][47:32], mask_q[hash], prio_q[hash], stat_q[hash], 1'b1);
                hit_q[hash] <= 1'b1;
              end else begin
                data_hi <= pack_hi(mac_in[47:32], {NPORTS{1'b1}}, '0, 1'b0, 1'b0);
              end
            end
            OP_READ: begin
              data_lo <= mac_q[entry_addr][31:0];
              data_hi <= pack_hi(mac_q[entry_addr][47:32], mask_q[entry_addr], prio_q[entry_addr],
                                 stat_q[entry_addr], vld_q[entry_addr]);
            end
            OP_WRITE: begin
              mac_q[entry_addr]  <= mac_in;
              mask_q[entry_addr] <= data_hi[MSK_B +: NPORTS];
              prio_q[entry_addr] <= data_hi[PRI_B +: PRIO_W];
              stat_q[entry_addr] <= data_hi[STA_B];
              vld_q[entry_addr]  <= data_hi[VLD_B];
              hit_q[entry_addr]  <= 1'b1;
            end
            default: begin
              mask_q[entry_addr] <= '0;
              prio_q[entry_addr] <= '0;
              stat_q[entry_addr] <= 1'b0;
              vld_q[entry_addr]  <= 1'b0;
              hit_q[entry_addr]  <= 1'b0;
            end
          endcase
        end
        default: begin
          sweep_idx <= sweep_idx + 1'b1;
          if (sweep_idx == AW'(ENTRIES - 1)) state <= ST_IDLE;
          if (op_q == OP_WIPE) begin
            mask_q[sweep_idx] <= '0;
            prio_q[sweep_idx] <= '0;
            stat_q[sweep_idx] <= 1'b0;
            vld_q[sweep_idx]  <= 1'b0;
            hit_q[sweep_idx]  <= 1'b0;
          end else begin
            mask_q[sweep_idx] <= mask_q[sweep_idx] & ~pm_q;
            if ((mask_q[sweep_idx] & ~pm_q) == '0) vld_q[sweep_idx] <= 1'b0;
          end
        end
      endcase

      if (wr_en && wr_sel == SEL_AGE) begin
        age_q <= wr_data[AGE_W-1:0];
        pre_q <= '0;  sub_q <= '0;  age_pend <= 1'b0;
      end else if (age_q == '0) begin
        pre_q <= '0;  sub_q <= '0;
      end else if (pre_q == PW'(PRESCALE - 1)) begin
        pre_q <= '0;
        if (sub_q == age_q - 1'b1) begin
          sub_q <= '0;
          age_pend <= 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> busy);
  assert_exec_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC) |=> !busy);
  assert_lo_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SWEEP && wr_en && wr_sel == SEL_LO) |=> $stable(data_lo));
  assert_miss_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && op_q == OP_LOOKUP && !match) |=>
      (data_hi[MSK_B +: NPORTS] == {NPORTS{1'b1}} && !data_hi[VLD_B]));
  assert_wipe_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clearing) |-> (vld_q == '0));
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    learn_count <= CW'(ENTRIES));
endmodule

// File: tb/sim_mac_table_ctrl.sv
`timescale 1ns/1ps
module sim_mac_table_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] data_lo, data_hi;
  logic busy, clearing;
  logic [4:0] entry_addr;
  logic [5:0] learn_count;

  mac_table_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_lo(data_lo), .data_hi(data_hi), .busy(busy), .entry_addr(entry_addr),
    .clearing(clearing), .learn_count(learn_count));

  always #4 clk = ~clk;

  typedef struct packed { logic [31:0] lo; logic [31:0] hi; logic [4:0] addr; logic cl, ch, ca; } exp_t;
  exp_t  q[$];
  string rq[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [47:0] m_mac [32];
  logic [4:0]  m_mask[32];
  logic [2:0]  m_prio[32];
  logic        m_st[32], m_vld[32];

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [4:0] h(input logic [47:0] m);
    logic [4:0] r = '0;
    for (int i = 0; i < 48; i += 5) r ^= 5'(m >> i);
    return r;
  endfunction

  function automatic logic [31:0] pk(input logic [15:0] mh, input logic [4:0] m, input logic [2:0] p,
                                     input logic s, input logic v);
    return {6'b0, v, s, p, m, mh};
  endfunction

  logic pbusy = 0;
  always @(negedge clk) begin
    if (pbusy && !busy && q.size() > 0) begin
      exp_t e;
      string r;
      e = q.pop_front();
      r = rq.pop_front();
      if (e.cl) chk(data_lo == e.lo, r, data_lo, e.lo);
      if (e.ch) chk(data_hi == e.hi, r, data_hi, e.hi);
      if (e.ca) chk(entry_addr == e.addr, r, {27'b0, entry_addr}, {27'b0, e.addr});
    end
    pbusy = busy;
  end

  task automatic host_wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic cmd(input logic [31:0] w, input exp_t e, input string r);
    q.push_back(e); rq.push_back(r);
    host_wr(3'd2, w);
    wait_idle();
  endtask

  task automatic lookup(input logic [47:0] m, input string r);
    exp_t e;
    logic [4:0] a = h(m);
    host_wr(3'd0, m[31:0]);
    host_wr(3'd1, {16'b0, m[47:32]});
    e = '{lo: 0, hi: 0, addr: a, cl: 0, ch: 1, ca: 1};
    if (m_vld[a] && m_mac[a] == m) e.hi = pk(m[47:32], m_mask[a], m_prio[a], m_st[a], 1'b1);
    else e.hi = pk(m[47:32], 5'h1f, 3'd0, 1'b0, 1'b0);
    cmd(32'h100, e, r);
  endtask

  task automatic wr_entry(input logic [4:0] a, input logic [47:0] m, input logic [4:0] mk,
                          input logic [2:0] p, input logic s);
    host_wr(3'd0, m[31:0]);
    host_wr(3'd1, pk(m[47:32], mk, p, s, 1'b1));
    cmd(32'h400 | a, '0, "R6");
    m_mac[a] = m; m_mask[a] = mk; m_prio[a] = p; m_st[a] = s; m_vld[a] = 1;
  endtask

  task automatic rd_entry(input logic [4:0] a, input string r);
    exp_t e;
    e = '{lo: m_mac[a][31:0], hi: pk(m_mac[a][47:32], m_mask[a], m_prio[a], m_st[a], m_vld[a]),
          addr: a, cl: 1, ch: 1, ca: 1};
    cmd(32'h200 | a, e, r);
  endtask

  localparam logic [47:0] MA = 48'h02A1_3C5D_7E9F;
  localparam logic [47:0] MB = MA ^ 48'h21;
  localparam logic [47:0] MC = 48'h0011_2233_4455;
  localparam logic [47:0] MD = 48'h00AA_BBCC_DDEE;
  localparam logic [47:0] ME = 48'h0180_C200_0000;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] ha;
    int nb, nc;
    for (int i = 0; i < 32; i++) begin
      m_mac[i] = 0; m_mask[i] = 0; m_prio[i] = 0; m_st[i] = 0; m_vld[i] = 0;
    end
    ha = h(MA);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !clearing, "R12 busy/clearing", {30'b0, busy, clearing}, 0);
    chk(learn_count == 0, "R12 learn_count", {26'b0, learn_count}, 0);
    chk(data_lo == 0 && data_hi == 0, "R12 data", data_hi, 0);
    rd_entry(5'd7, "R12 slot invalid");

    lookup(MA, "R3 R5 miss on empty slot");
    wr_entry(ha, MA, 5'h04, 3'd5, 1'b0);
    lookup(MA, "R4 hit returns fields");

    // R1: read finishes one cycle after busy rises
    q.push_back('{lo: MA[31:0], hi: pk(MA[47:32], 5'h04, 3'd5, 1'b0, 1'b1), addr: ha, cl: 1, ch: 1, ca: 1});
    rq.push_back("R6 read by address");
    host_wr(3'd2, 32'h200 | ha);
    chk(busy, "R1 busy after accept", {31'b0, busy}, 1);
    @(negedge clk);
    chk(!busy, "R1 single op one cycle", {31'b0, busy}, 0);

    lookup(MB, "R5 collision miss");

    // R10 learn count
    host_wr(3'd3, 1); host_wr(3'd3, 1); host_wr(3'd3, 2);
    chk(learn_count == 1, "R10 inc/dec", {26'b0, learn_count}, 1);
    host_wr(3'd3, 0);
    chk(learn_count == 1, "R10 mode 0 no effect", {26'b0, learn_count}, 1);
    host_wr(3'd3, 3);
    chk(learn_count == 0, "R10 zero", {26'b0, learn_count}, 0);
    host_wr(3'd3, 2);
    chk(learn_count == 0, "R10 dec floor", {26'b0, learn_count}, 0);
    for (int i = 0; i < 33; i++) host_wr(3'd3, 1);
    chk(learn_count == 32, "R10 inc ceiling", {26'b0, learn_count}, 32);

    wr_entry(ha ^ 5'd1, MC, 5'h03, 3'd1, 1'b0);
    wr_entry(ha ^ 5'd2, MD, 5'h02, 3'd2, 1'b0);
    wr_entry(ha ^ 5'd3, ME, 5'h1f, 3'd7, 1'b1);

    // R8 port removal, R2 commands and data writes during sweep ignored
    q.push_back('0); rq.push_back("R8");
    host_wr(3'd2, 32'h1000 | 32'h02);
    chk(busy && !clearing, "R1 sweep busy, not wipe", {30'b0, busy, clearing}, 2);
    host_wr(3'd2, 32'h800 | (ha ^ 5'd1));
    host_wr(3'd0, 32'hDEAD_BEEF);
    wait_idle();
    for (int i = 0; i < 32; i++) begin
      m_mask[i] = m_mask[i] & ~5'h02;
      if (m_mask[i] == 0) m_vld[i] = 0;
    end
    chk(data_lo == ME[31:0], "R2 data write ignored while busy", data_lo, ME[31:0]);
    rd_entry(ha ^ 5'd1, "R2 R8 entry kept, mask trimmed");
    rd_entry(ha ^ 5'd2, "R8 emptied entry invalid");
    rd_entry(ha, "R8 other entry unchanged");

    cmd(32'h800 | (ha ^ 5'd1), '0, "R7");
    m_mask[ha ^ 5'd1] = 0; m_prio[ha ^ 5'd1] = 0; m_st[ha ^ 5'd1] = 0; m_vld[ha ^ 5'd1] = 0;
    rd_entry(ha ^ 5'd1, "R7 cleared slot");

    host_wr(3'd2, 32'h0000_0001);
    chk(!busy, "R2 no op bit ignored", {31'b0, busy}, 0);

    // R11 ageing
    wr_entry(ha ^ 5'd1, MC, 5'h03, 3'd1, 1'b0);
    host_wr(3'd4, 1);
    repeat (100 * 1024) @(negedge clk);
    host_wr(3'd4, 0);
    m_vld[ha] = 0; m_vld[ha ^ 5'd1] = 0;
    rd_entry(ha, "R11 dynamic entry aged out");
    rd_entry(ha ^ 5'd1, "R11 second dynamic entry aged out");
    rd_entry(ha ^ 5'd3, "R11 static entry kept");

    // R9 table wipe
    wr_entry(ha, MA, 5'h04, 3'd5, 1'b0);
    q.push_back('0); rq.push_back("R9");
    host_wr(3'd2, 32'h2000);
    nb = 0; nc = 0;
    while (busy) begin
      nb++;
      if (clearing) nc++;
      @(negedge clk);
    end
    chk(nb == 32, "R1 sweep length", nb, 32);
    chk(nc == 32, "R9 clearing during wipe", nc, 32);
    for (int i = 0; i < 32; i++) begin
      m_mask[i] = 0; m_prio[i] = 0; m_st[i] = 0; m_vld[i] = 0;
    end
    rd_entry(ha, "R9 entry wiped");
    rd_entry(ha ^ 5'd3, "R9 static entry wiped");
    lookup(MA, "R9 lookup misses after wipe");
    chk(learn_count == 32, "R10 count untouched by commands", {26'b0, learn_count}, 32);

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R1 all commands completed", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule